// File: doc/BRIEF.md
# Double-Buffered Audio Transfer Sequencer

This block moves 32-bit audio words between a serial audio engine and system memory for a receive and a transmit direction. Software places a buffer base pointer for each direction in an input register, and the block copies that pointer into a private shadow register whenever a buffer begins. Each copy raises a pointer-updated event for that direction. From then on the pointer input is free again, so software can load the address of the next buffer while the current one is still being filled or drained.

The buffer length is counted in words and is shared by both directions. Each direction has its own enable, and a direction that is not enabled when the transfer is started makes no memory accesses. The memory side is a single address/strobe/ready port that is shared by both directions. Receive traffic wins when both directions are waiting, because a received word that is not stored is lost. A stop command lets the access that is already on the port finish and then raises a stopped event. Four event flags (receive pointer updated, transmit pointer updated, stopped, frame start) feed one interrupt line through an enable mask that has separate set and clear inputs.

Top module: `audio_xfer_seq`

## Requirements
- R1: After reset all event flags and interrupt enables are zero, `irq_o` is low, and neither memory strobe is asserted.
- R2: A start command copies `rx_ptr_i` into the receive shadow and sets event flag bit 0. Received words are then written to the shadow value plus 0, 1, 2, and so on, in the order they arrive.
- R3: When the word that completes `buf_words_i` words of a buffer has been transferred, the current pointer input is copied into the shadow, the word index returns to zero, and the pointer-updated flag sets again. A size of 1 reloads after every word.
- R4: A direction whose enable is low at start makes no memory access for its requests, and its pointer-updated flag (bit 1 for transmit) stays clear.
- R5: Each transmit request reads memory at the transmit shadow plus the word index. The word that was read appears on `tx_word_o` together with a one-cycle `tx_word_vld_o` pulse.
- R6: When a receive word and a transmit request are both waiting and the port is free, the receive write is issued first.
- R7: A stop command lets the access already on the port complete, then sets event flag bit 2. No memory access follows until the next start.
- R8: A strobe (`mem_wr_o` or `mem_rd_o`, never both) keeps its address and stays asserted until `mem_rdy_i` is sampled high.
- R9: A bit of `evt_clr_i` clears the matching event flag. An event that occurs in the same cycle wins over the clear.
- R10: `ien_set_i` and `ien_clr_i` set and clear interrupt enable bits, which can be read back on `ien_o` (a set wins over a clear). `irq_o` is high when any flag is set together with its enable bit.
- R11: `frame_start_i` sets event flag bit 3 only while a transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_ptr_i | input | AW | Next receive buffer base (word address) |
| tx_ptr_i | input | AW | Next transmit buffer base (word address) |
| buf_words_i | input | CW | Buffer length in words, shared by both directions |
| rx_en_i | input | 1 | Receive direction enable, sampled at start |
| tx_en_i | input | 1 | Transmit direction enable, sampled at start |
| start_i | input | 1 | Start command pulse |
| stop_i | input | 1 | Stop command pulse |
| frame_start_i | input | 1 | Frame boundary pulse from the serializer |
| rx_word_req_i | input | 1 | A received word is presented |
| rx_word_i | input | DW | Received word |
| tx_word_req_i | input | 1 | Serializer asks for the next transmit word |
| tx_word_o | output | DW | Transmit word fetched from memory |
| tx_word_vld_o | output | 1 | One-cycle pulse: `tx_word_o` is new |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Memory write data |
| mem_wr_o | output | 1 | Write strobe |
| mem_rd_o | output | 1 | Read strobe |
| mem_rdata_i | input | DW | Read data, valid with `mem_rdy_i` |
| mem_rdy_i | input | 1 | Access completes in this cycle |
| evt_clr_i | input | 4 | Clear event flags: bit 0 rx pointer, 1 tx pointer, 2 stopped, 3 frame start |
| evt_flags_o | output | 4 | Event flags, same bit order |
| ien_set_i | input | 4 | Interrupt enable set mask |
| ien_clr_i | input | 4 | Interrupt enable clear mask |
| ien_o | output | 4 | Interrupt enable readback |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with a 16-bit address, a 14-bit length field and 32-bit words, which leaves room for small buffers placed anywhere in a 256-word memory model. With buffer lengths of 4 and 1, the wrap-and-reload path runs within a few words. That makes it possible to see a pointer written in the middle of a buffer take effect exactly at the next buffer. A ready signal that the bench controls holds a write on the port for several cycles, so a stop can be placed on top of an access that has not yet completed.

// File: rtl/axs_pkg.sv
package axs_pkg;
    localparam int EV_N      = 4;
    localparam int EV_RXUPD  = 0;
    localparam int EV_TXUPD  = 1;
    localparam int EV_STOP   = 2;
    localparam int EV_FRAME  = 3;

    typedef enum logic [1:0] {
        PORT_IDLE = 2'd0,
        PORT_WR   = 2'd1,
        PORT_RD   = 2'd2
    } port_st_e;
endpackage

// File: rtl/axs_chan.sv
// One transfer direction: shadow base, word index and pending request.
module axs_chan #(
    parameter int AW = 16,
    parameter int CW = 14
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [AW-1:0] ptr_i,
    input  logic [CW-1:0] size_i,
    input  logic          req_i,
    input  logic          done_i,
    input  logic          flush_i,
    output logic          pend_o,
    output logic [AW-1:0] addr_o,
    output logic          upd_o
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [CW-1:0] idx;
        logic          pend;
        logic          upd;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic [CW:0] idx_inc;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        idx_inc  = {1'b0, st_q.idx} + {{CW{1'b0}}, 1'b1};
        if (req_i) begin
            st_d.pend = 1'b1;
        end
        if (done_i) begin
            st_d.pend = req_i;
            if (idx_inc >= {1'b0, size_i}) begin
                st_d.base = ptr_i;
                st_d.idx  = '0;
                st_d.upd  = 1'b1;
            end else begin
                st_d.idx = idx_inc[CW-1:0];
            end
        end
        if (load_i) begin
            st_d.base = ptr_i;
            st_d.idx  = '0;
            st_d.upd  = 1'b1;
            st_d.pend = 1'b0;
        end
        if (flush_i) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign addr_o = st_q.base + {{(AW-CW){1'b0}}, st_q.idx};
    assign upd_o  = st_q.upd;
endmodule

// File: rtl/axs_port.sv
// Shared memory port: one access at a time, receive before transmit.
module axs_port #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          hold_i,
    input  logic          rx_pend_i,
    input  logic          tx_pend_i,
    input  logic [AW-1:0] rx_addr_i,
    input  logic [AW-1:0] tx_addr_i,
    input  logic [DW-1:0] rx_data_i,
    input  logic          mem_rdy_i,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic          mem_wr_o,
    output logic          mem_rd_o,
    output logic          rx_done_o,
    output logic          tx_done_o,
    output logic          busy_o
);
    import axs_pkg::*;

    typedef struct packed {
        port_st_e      st;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } port_t;

    port_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        unique case (p_q.st)
            PORT_IDLE: begin
                if (!hold_i) begin
                    if (rx_pend_i) begin
                        p_d.st    = PORT_WR;
                        p_d.addr  = rx_addr_i;
                        p_d.wdata = rx_data_i;
                    end else if (tx_pend_i) begin
                        p_d.st   = PORT_RD;
                        p_d.addr = tx_addr_i;
                    end
                end
            end
            PORT_WR, PORT_RD: begin
                if (mem_rdy_i) begin
                    p_d.st = PORT_IDLE;
                end
            end
            default: p_d.st = PORT_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            p_q <= '{st: PORT_IDLE, addr: '0, wdata: '0};
        end else begin
            p_q <= p_d;
        end
    end

    assign mem_addr_o  = p_q.addr;
    assign mem_wdata_o = p_q.wdata;
    assign mem_wr_o    = (p_q.st == PORT_WR);
    assign mem_rd_o    = (p_q.st == PORT_RD);
    assign rx_done_o   = mem_wr_o && mem_rdy_i;
    assign tx_done_o   = mem_rd_o && mem_rdy_i;
    assign busy_o      = (p_q.st != PORT_IDLE);
endmodule

// File: rtl/axs_events.sv
// Event flags, interrupt enable mask and interrupt line.
module axs_events (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [axs_pkg::EV_N-1:0] set_i,
    input  logic [axs_pkg::EV_N-1:0] clr_i,
    input  logic [axs_pkg::EV_N-1:0] ien_set_i,
    input  logic [axs_pkg::EV_N-1:0] ien_clr_i,
    output logic [axs_pkg::EV_N-1:0] flags_o,
    output logic [axs_pkg::EV_N-1:0] ien_o,
    output logic                    irq_o
);
    import axs_pkg::*;

    typedef struct packed {
        logic [EV_N-1:0] flags;
        logic [EV_N-1:0] ien;
        logic            irq;
    } ev_t;

    ev_t e_d, e_q;

    always_comb begin
        e_d       = e_q;
        e_d.flags = (e_q.flags & ~clr_i) | set_i;
        e_d.ien   = (e_q.ien & ~ien_clr_i) | ien_set_i;
        e_d.irq   = 1'b0;
        for (int k = 0; k < EV_N; k++) begin
            e_d.irq = e_d.irq | (e_d.flags[k] & e_d.ien[k]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign flags_o = e_q.flags;
    assign ien_o   = e_q.ien;
    assign irq_o   = e_q.irq;
endmodule

// File: rtl/audio_xfer_seq.sv
module audio_xfer_seq #(
    parameter int AW = 16,
    parameter int CW = 14,
    parameter int DW = 32
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [AW-1:0]            rx_ptr_i,
    input  logic [AW-1:0]            tx_ptr_i,
    input  logic [CW-1:0]            buf_words_i,
    input  logic                     rx_en_i,
    input  logic                     tx_en_i,
    input  logic                     start_i,
    input  logic                     stop_i,
    input  logic                     frame_start_i,
    input  logic                     rx_word_req_i,
    input  logic [DW-1:0]            rx_word_i,
    input  logic                     tx_word_req_i,
    output logic [DW-1:0]            tx_word_o,
    output logic                     tx_word_vld_o,
    output logic [AW-1:0]            mem_addr_o,
    output logic [DW-1:0]            mem_wdata_o,
    output logic                     mem_wr_o,
    output logic                     mem_rd_o,
    input  logic [DW-1:0]            mem_rdata_i,
    input  logic                     mem_rdy_i,
    input  logic [axs_pkg::EV_N-1:0] evt_clr_i,
    output logic [axs_pkg::EV_N-1:0] evt_flags_o,
    input  logic [axs_pkg::EV_N-1:0] ien_set_i,
    input  logic [axs_pkg::EV_N-1:0] ien_clr_i,
    output logic [axs_pkg::EV_N-1:0] ien_o,
    output logic                     irq_o
);
    import axs_pkg::*;

    localparam int NDIR = 2;
    localparam int DRX  = 0;
    localparam int DTX  = 1;

    typedef struct packed {
        logic          run;
        logic          stopping;
        logic          rx_on;
        logic          tx_on;
        logic [DW-1:0] rxd;
        logic [DW-1:0] txw;
        logic          txv;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic            start_go, stop_done, port_busy;
    logic [NDIR-1:0] ch_load, ch_req, ch_done, ch_pend, ch_upd;
    logic [AW-1:0]   ch_addr [NDIR];
    logic [AW-1:0]   ch_ptr  [NDIR];
    logic [EV_N-1:0] ev_set;

    assign start_go  = start_i && !ctl_q.run;
    assign stop_done = ctl_q.stopping && !port_busy;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.txv = 1'b0;
        if (start_go) begin
            ctl_d.run   = 1'b1;
            ctl_d.rx_on = rx_en_i;
            ctl_d.tx_on = tx_en_i;
        end
        if (ctl_q.run && stop_i) begin
            ctl_d.stopping = 1'b1;
        end
        if (stop_done) begin
            ctl_d.run      = 1'b0;
            ctl_d.stopping = 1'b0;
        end
        if (ch_req[DRX]) begin
            ctl_d.rxd = rx_word_i;
        end
        if (ch_done[DTX]) begin
            ctl_d.txw = mem_rdata_i;
            ctl_d.txv = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ch_ptr[DRX]  = rx_ptr_i;
    assign ch_ptr[DTX]  = tx_ptr_i;
    assign ch_load[DRX] = start_go && rx_en_i;
    assign ch_load[DTX] = start_go && tx_en_i;
    assign ch_req[DRX]  = rx_word_req_i && ctl_q.run && ctl_q.rx_on && !ctl_q.stopping;
    assign ch_req[DTX]  = tx_word_req_i && ctl_q.run && ctl_q.tx_on && !ctl_q.stopping;

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        axs_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .load_i  (ch_load[g]),
            .ptr_i   (ch_ptr[g]),
            .size_i  (buf_words_i),
            .req_i   (ch_req[g]),
            .done_i  (ch_done[g]),
            .flush_i (stop_done),
            .pend_o  (ch_pend[g]),
            .addr_o  (ch_addr[g]),
            .upd_o   (ch_upd[g])
        );
    end

    axs_port #(.AW(AW), .DW(DW)) u_port (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .hold_i      (!ctl_q.run || ctl_q.stopping),
        .rx_pend_i   (ch_pend[DRX]),
        .tx_pend_i   (ch_pend[DTX]),
        .rx_addr_i   (ch_addr[DRX]),
        .tx_addr_i   (ch_addr[DTX]),
        .rx_data_i   (ctl_q.rxd),
        .mem_rdy_i   (mem_rdy_i),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_wr_o    (mem_wr_o),
        .mem_rd_o    (mem_rd_o),
        .rx_done_o   (ch_done[DRX]),
        .tx_done_o   (ch_done[DTX]),
        .busy_o      (port_busy)
    );

    always_comb begin
        ev_set           = '0;
        ev_set[EV_RXUPD] = ch_upd[DRX];
        ev_set[EV_TXUPD] = ch_upd[DTX];
        ev_set[EV_STOP]  = stop_done;
        ev_set[EV_FRAME] = frame_start_i && ctl_q.run;
    end

    axs_events u_events (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (ev_set),
        .clr_i     (evt_clr_i),
        .ien_set_i (ien_set_i),
        .ien_clr_i (ien_clr_i),
        .flags_o   (evt_flags_o),
        .ien_o     (ien_o),
        .irq_o     (irq_o)
    );

    assign tx_word_o     = ctl_q.txw;
    assign tx_word_vld_o = ctl_q.txv;
endmodule

// File: rtl/axs_checker.sv
module axs_checker #(
    parameter int AW = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          run_i,
    input logic          mem_wr_i,
    input logic          mem_rd_i,
    input logic [AW-1:0] mem_addr_i,
    input logic          mem_rdy_i,
    input logic [3:0]    ien_set_i,
    input logic [3:0]    ien_clr_i,
    input logic          irq_i,
    input logic [3:0]    evt_clr_i,
    input logic          frame_start_i,
    input logic [3:0]    evt_flags_i
);
    // R8: never a read and a write at once
    a_r8_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mem_wr_i && mem_rd_i));

    // R8: an unanswered access holds address and strobe
    a_r8_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((mem_wr_i || mem_rd_i) && !mem_rdy_i) |=>
            ($stable(mem_addr_i) && $stable(mem_wr_i) && $stable(mem_rd_i)));

    // R7: port is quiet whenever no transfer runs
    a_r7_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |-> !(mem_wr_i || mem_rd_i));

    // R7: the stopped flag rises only with the port quiet
    a_r7_stop_after_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(evt_flags_i[2]) |-> !(mem_wr_i || mem_rd_i));

    // R10: clearing every enable drops the interrupt
    a_r10_all_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ien_clr_i == 4'hF && ien_set_i == 4'h0) |=> !irq_i);

    // R9: a clear with no competing event empties the frame flag
    a_r9_clear_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_clr_i[3] && !frame_start_i) |=> !evt_flags_i[3]);
endmodule

bind audio_xfer_seq axs_checker #(.AW(AW)) u_axs_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (ctl_q.run),
    .mem_wr_i      (mem_wr_o),
    .mem_rd_i      (mem_rd_o),
    .mem_addr_i    (mem_addr_o),
    .mem_rdy_i     (mem_rdy_i),
    .ien_set_i     (ien_set_i),
    .ien_clr_i     (ien_clr_i),
    .irq_i         (irq_o),
    .evt_clr_i     (evt_clr_i),
    .frame_start_i (frame_start_i),
    .evt_flags_i   (evt_flags_o)
);

// File: tb/audio_xfer_seq_bench.sv
`timescale 1ns/1ps
module audio_xfer_seq_bench;
    localparam int AW = 16;
    localparam int CW = 14;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [AW-1:0] rx_ptr = '0, tx_ptr = '0;
    logic [CW-1:0] buf_words = 14'd4;
    logic rx_en = 1'b0, tx_en = 1'b0, start = 1'b0, stop = 1'b0, frame = 1'b0;
    logic rx_req = 1'b0, tx_req = 1'b0;
    logic [DW-1:0] rx_word = '0;
    logic [DW-1:0] tx_word;
    logic tx_vld;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wdata, m_rdata;
    logic m_wr, m_rd;
    logic rdy_ok = 1'b1;
    logic [3:0] evt_clr = '0, ien_set = '0, ien_clr = '0;
    logic [3:0] flags, ien;
    logic irq;

    audio_xfer_seq #(.AW(AW), .CW(CW), .DW(DW)) u_audio_xfer_seq (
        .clk_i(clk), .rst_ni(rst_n),
        .rx_ptr_i(rx_ptr), .tx_ptr_i(tx_ptr), .buf_words_i(buf_words),
        .rx_en_i(rx_en), .tx_en_i(tx_en), .start_i(start), .stop_i(stop),
        .frame_start_i(frame), .rx_word_req_i(rx_req), .rx_word_i(rx_word),
        .tx_word_req_i(tx_req), .tx_word_o(tx_word), .tx_word_vld_o(tx_vld),
        .mem_addr_o(m_addr), .mem_wdata_o(m_wdata), .mem_wr_o(m_wr), .mem_rd_o(m_rd),
        .mem_rdata_i(m_rdata), .mem_rdy_i(rdy_ok),
        .evt_clr_i(evt_clr), .evt_flags_o(flags),
        .ien_set_i(ien_set), .ien_clr_i(ien_clr), .ien_o(ien), .irq_o(irq)
    );

    // memory model and access log
    logic [31:0] mem [256];
    logic [31:0] preload_val [4];
    logic        preload = 1'b0;
    logic [7:0]  preload_at = '0;
    assign m_rdata = mem[m_addr[7:0]];

    logic        log_clr = 1'b0;
    int          acnt, tcnt;
    logic        akind [64];
    logic [15:0] aaddr [64];
    logic [31:0] adata [64];
    logic [31:0] tdata [64];

    always @(posedge clk) begin
        if (preload) begin
            for (int i = 0; i < 4; i++) mem[preload_at + 8'(i)] <= preload_val[i];
        end
        if (log_clr) begin
            acnt <= 0;
            tcnt <= 0;
        end else begin
            if ((m_wr || m_rd) && rdy_ok && acnt < 64) begin
                akind[acnt] <= m_wr;
                aaddr[acnt] <= m_addr;
                adata[acnt] <= m_wr ? m_wdata : m_rdata;
                acnt <= acnt + 1;
                if (m_wr) mem[m_addr[7:0]] <= m_wdata;
            end
            if (tx_vld && tcnt < 64) begin
                tdata[tcnt] <= tx_word;
                tcnt <= tcnt + 1;
            end
        end
    end

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_log();
        log_clr = 1'b1;
        tick(1);
        log_clr = 1'b0;
    endtask

    task automatic clear_flags();
        evt_clr = 4'hF;
        tick(1);
        evt_clr = 4'h0;
    endtask

    task automatic do_start();
        start = 1'b1;
        tick(1);
        start = 1'b0;
        tick(2);
    endtask

    task automatic do_stop();
        stop = 1'b1;
        tick(1);
        stop = 1'b0;
        tick(3);
    endtask

    task automatic push_rx(input logic [31:0] d);
        rx_word = d;
        rx_req = 1'b1;
        tick(1);
        rx_req = 1'b0;
        tick(4);
    endtask

    task automatic pull_tx();
        tx_req = 1'b1;
        tick(1);
        tx_req = 1'b0;
        tick(4);
    endtask

    task automatic t_reset();
        chk("R1 flags", 32'(flags), 32'h0);
        chk("R1 enables", 32'(ien), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 strobes", 32'({m_wr, m_rd}), 32'h0);
    endtask

    task automatic t_rx_wrap();
        clear_log();
        buf_words = 14'd4;
        rx_ptr = 16'h0010;
        rx_en = 1'b1;
        tx_en = 1'b0;
        do_start();
        chk("R2 rx pointer event", 32'(flags[0]), 32'h1);
        chk("R4 tx pointer event off", 32'(flags[1]), 32'h0);
        rx_ptr = 16'h0040;
        evt_clr = 4'h1;
        tick(1);
        evt_clr = 4'h0;
        push_rx(32'hA000_0000);
        push_rx(32'hA000_0001);
        push_rx(32'hA000_0002);
        chk("R3 no reload mid-buffer", 32'(flags[0]), 32'h0);
        push_rx(32'hA000_0003);
        chk("R3 reload event", 32'(flags[0]), 32'h1);
        push_rx(32'hA000_0004);
        tx_req = 1'b1;
        tick(1);
        tx_req = 1'b0;
        tick(4);
        chk("R2 write count", 32'(acnt), 32'd5);
        for (int i = 0; i < 4; i++) begin
            chk("R2 write addr", 32'(aaddr[i]), 32'h10 + 32'(i));
            chk("R2 write data", adata[i], 32'hA000_0000 + 32'(i));
        end
        chk("R3 new buffer addr", 32'(aaddr[4]), 32'h40);
        chk("R4 no tx word", 32'(tcnt), 32'd0);
        do_stop();
        chk("R7 stopped event", 32'(flags[2]), 32'h1);
        rx_en = 1'b0;
    endtask

    task automatic t_tx();
        clear_flags();
        preload_val[0] = 32'hC0DE_0000;
        preload_val[1] = 32'hC0DE_0001;
        preload_val[2] = 32'hC0DE_0002;
        preload_val[3] = 32'hC0DE_0003;
        preload_at = 8'h80;
        preload = 1'b1;
        tick(1);
        preload = 1'b0;
        clear_log();
        tx_ptr = 16'h0080;
        tx_en = 1'b1;
        do_start();
        chk("R5 tx pointer event", 32'(flags[1]), 32'h1);
        chk("R4 rx pointer event off", 32'(flags[0]), 32'h0);
        pull_tx();
        pull_tx();
        pull_tx();
        chk("R5 tx words", 32'(tcnt), 32'd3);
        for (int i = 0; i < 3; i++) begin
            chk("R5 read addr", 32'(aaddr[i]), 32'h80 + 32'(i));
            chk("R5 read kind", 32'(akind[i]), 32'h0);
            chk("R5 tx data", tdata[i], 32'hC0DE_0000 + 32'(i));
        end
        do_stop();
        tx_en = 1'b0;
    endtask

    task automatic t_prio();
        clear_log();
        rx_ptr = 16'h0020;
        tx_ptr = 16'h0090;
        buf_words = 14'd8;
        rx_en = 1'b1;
        tx_en = 1'b1;
        do_start();
        rx_word = 32'h5555_AAAA;
        rx_req = 1'b1;
        tx_req = 1'b1;
        tick(1);
        rx_req = 1'b0;
        tx_req = 1'b0;
        tick(8);
        chk("R6 two accesses", 32'(acnt), 32'd2);
        chk("R6 write first", 32'(akind[0]), 32'h1);
        chk("R6 write addr", 32'(aaddr[0]), 32'h20);
        chk("R6 read second", 32'(akind[1]), 32'h0);
        chk("R6 read addr", 32'(aaddr[1]), 32'h90);
        do_stop();
        tx_en = 1'b0;
    endtask

    task automatic t_stop_inflight();
        clear_flags();
        clear_log();
        rx_ptr = 16'h0030;
        rx_en = 1'b1;
        do_start();
        rdy_ok = 1'b0;
        rx_word = 32'hDEAD_0030;
        rx_req = 1'b1;
        tick(1);
        rx_req = 1'b0;
        tick(2);
        chk("R8 write asserted", 32'(m_wr), 32'h1);
        stop = 1'b1;
        tick(1);
        stop = 1'b0;
        tick(5);
        chk("R8 write still held", 32'(m_wr), 32'h1);
        chk("R8 addr held", 32'(m_addr), 32'h30);
        chk("R7 not stopped yet", 32'(flags[2]), 32'h0);
        rdy_ok = 1'b1;
        tick(4);
        chk("R7 in-flight write done", 32'(acnt), 32'd1);
        chk("R7 in-flight data", adata[0], 32'hDEAD_0030);
        chk("R7 stopped after access", 32'(flags[2]), 32'h1);
        push_rx(32'h1111_2222);
        chk("R7 no access after stop", 32'(acnt), 32'd1);
        chk("R7 strobes low", 32'({m_wr, m_rd}), 32'h0);
        rx_en = 1'b0;
    endtask

    task automatic t_irq();
        clear_flags();
        ien_set = 4'b0100;
        tick(2);
        ien_set = 4'b0000;
        chk("R10 enable readback", 32'(ien), 32'h4);
        chk("R10 no irq without flag", 32'(irq), 32'h0);
        rx_en = 1'b1;
        do_start();
        chk("R10 unmasked flag no irq", 32'(irq), 32'h0);
        do_stop();
        chk("R10 irq on stopped", 32'(irq), 32'h1);
        ien_clr = 4'b0100;
        tick(2);
        ien_clr = 4'b0000;
        chk("R10 irq masked", 32'(irq), 32'h0);
        chk("R10 enable cleared", 32'(ien), 32'h0);
        evt_clr = 4'b0100;
        tick(2);
        evt_clr = 4'b0000;
        chk("R9 stopped flag cleared", 32'(flags[2]), 32'h0);
        chk("R9 other flag kept", 32'(flags[0]), 32'h1);
        rx_en = 1'b0;
    endtask

    task automatic t_frame();
        clear_flags();
        rx_en = 1'b1;
        do_start();
        frame = 1'b1;
        tick(1);
        frame = 1'b0;
        tick(1);
        chk("R11 frame while running", 32'(flags[3]), 32'h1);
        evt_clr = 4'b1000;
        frame = 1'b1;
        tick(1);
        evt_clr = 4'b0000;
        frame = 1'b0;
        tick(1);
        chk("R9 event wins over clear", 32'(flags[3]), 32'h1);
        evt_clr = 4'b1000;
        tick(1);
        evt_clr = 4'b0000;
        tick(1);
        chk("R9 frame flag cleared", 32'(flags[3]), 32'h0);
        do_stop();
        frame = 1'b1;
        tick(1);
        frame = 1'b0;
        tick(2);
        chk("R11 frame ignored when idle", 32'(flags[3]), 32'h0);
        rx_en = 1'b0;
    endtask

    task automatic t_size_one();
        clear_log();
        buf_words = 14'd1;
        rx_ptr = 16'h0050;
        rx_en = 1'b1;
        do_start();
        rx_ptr = 16'h0060;
        push_rx(32'h0000_0050);
        push_rx(32'h0000_0060);
        chk("R3 size1 count", 32'(acnt), 32'd2);
        chk("R3 size1 first addr", 32'(aaddr[0]), 32'h50);
        chk("R3 size1 second addr", 32'(aaddr[1]), 32'h60);
        do_stop();
        rx_en = 1'b0;
    endtask

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_rx_wrap();
        t_tx();
        t_prio();
        t_stop_inflight();
        t_irq();
        t_frame();
        t_size_one();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule